// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Mirror Controller

This block keeps the interrupt state of a two-channel IDE host controller. Each channel's pending interrupt is held in two configuration locations: a legacy status byte for that channel and a shared UDMA-mode status byte. The two locations always agree. Software clears a pending interrupt by writing a one to it in either location. A per-channel block bit masks that channel out of the single shared PCI interrupt line.

A channel's interrupt bit follows its level input, but only when that input changes. Configuration writes arrive dword-wide with byte enables and can only clear interrupt bits. The block bits are changed only through a separate update port that a bus-master register window drives. The block also supplies the constant bytes that configuration space shows at reset: the channel-enable control byte, the programming-interface byte and the interrupt-pin byte. Configuration read data is combinational from the dword index.

Top module: `ide_irq_mirror`

## Requirements
- R1: After reset, all interrupt and block bits are clear and `irqOut` is low. `ctrlByte` is 0x04, or 0x0C when `SECONDARY_EN` is set. `progIfByte` is 0x8F and `intPinByte` is 0x01. These three bytes also read back at byte addresses 0x51, 0x09 and 0x3D.
- R2: Layout. Byte 0x50 bit 2 is the legacy channel 0 interrupt, and byte 0x57 bit 4 is the legacy channel 1 interrupt. In byte 0x71, bits 2 and 3 are the channel 0 and channel 1 interrupts, and bits 4 and 5 are the channel 0 and channel 1 block bits. Byte address A is returned on `cfgRdData[8*(A%4)+:8]` when `cfgRdDw` equals A/4.
- R3: The legacy copy and the byte 0x71 copy of each channel's interrupt always hold the same value.
- R4: When `chanIrq[c]` differs from its value in the previous cycle, both copies of channel c's interrupt take the new level at the next clock edge.
- R5: A configuration write with a one in an enabled lane at any interrupt bit clears both copies of that channel's interrupt at the next edge. Writing a zero leaves the bit unchanged. A level change in the same cycle takes priority over the clear.
- R6: All other bits of bytes 0x50, 0x57 and 0x71 ignore configuration writes, and so does the control byte 0x51. This includes the block bits.
- R7: When `blkWrEn` is high, the block bits are loaded from `blkWrData` at the next edge (bit 0 is channel 0). Otherwise they hold.
- R8: `irqOut` equals (ch0 interrupt AND NOT ch0 block) OR (ch1 interrupt AND NOT ch1 block), taken from the registered state. It therefore changes one edge after the event that causes the change.
- R9: An interrupt cleared by software while its input stays high remains clear until the input changes level again.
- R10: A configuration write whose byte enable for a lane is low has no effect through that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanIrq | input | 2 | Channel interrupt levels, bit c is channel c |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrDw | input | 6 | Dword index of the write (byte address / 4) |
| cfgByteEn | input | 4 | Byte-lane enables of the write |
| cfgWrData | input | 32 | Write data, byte lane n at bits 8n+7:8n |
| blkWrEn | input | 1 | Block-bit update strobe from the bus-master window |
| blkWrData | input | 2 | New block bits |
| cfgRdDw | input | 6 | Dword index to read |
| cfgRdData | output | 32 | Read data for `cfgRdDw` |
| irqOut | output | 1 | Shared PCI interrupt line |
| ctrlByte | output | 8 | Channel-enable control byte |
| progIfByte | output | 8 | Programming-interface byte |
| intPinByte | output | 8 | Interrupt-pin byte |

## Verification
The hardest case to reach is a software clear that lands in the same cycle as a level change on the same channel. A close second is a clear made while the input stays high, after which the bit must stay clear. The vector table first raises a channel, clears it through the other mirror location, and then holds the input steady for several vectors. A directed step then drives a rising input and a one-to-clear write to the legacy byte in the same cycle. After that step, both mirror locations are read back.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam logic [7:0] LEG0_OFS   = 8'h50;
  localparam logic [7:0] CTRL_OFS   = 8'h51;
  localparam logic [7:0] LEG1_OFS   = 8'h57;
  localparam logic [7:0] UDMA_OFS   = 8'h71;
  localparam logic [7:0] PROGIF_OFS = 8'h09;
  localparam logic [7:0] PIN_OFS    = 8'h3D;
  localparam int LEG0_BIT = 2;
  localparam int LEG1_BIT = 4;
  localparam int UINT_BIT = 2;
  localparam int UBLK_BIT = 4;
  localparam int NUM_CH   = 2;
  localparam logic [7:0] PROGIF_VAL = 8'h8F;
  localparam logic [7:0] PIN_VAL    = 8'h01;

  typedef struct packed {
    logic [NUM_CH-1:0] lvlChg;
    logic [NUM_CH-1:0] lvlVal;
    logic [NUM_CH-1:0] w1c;
    logic              blkWr;
    logic [NUM_CH-1:0] blkVal;
  } strobe_t;
endpackage

// File: rtl/ide_irq_ctrl.sv
module ide_irq_ctrl
  import ide_irq_pkg::*;
#(
  parameter int DW_W   = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanIrq,
  input  logic              cfgWrEn,
  input  logic [DW_W-1:0]   cfgWrDw,
  input  logic [DATA_W/8-1:0] cfgByteEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              blkWrEn,
  input  logic [NUM_CH-1:0] blkWrData,
  output strobe_t           strb
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES);
  localparam int BA_W  = DW_W + LW;

  logic [NUM_CH-1:0] prevIrq;
  logic [LANES-1:0]  hit0, hit1;

  always_ff @(posedge clk) begin
    if (!rstN) prevIrq <= '0;
    else       prevIrq <= chanIrq;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BA_W-1:0] byteAddr;
    logic [7:0]      laneByte;
    logic            laneOn;
    assign byteAddr = {cfgWrDw, LW'(l)};
    assign laneByte = cfgWrData[8*l +: 8];
    assign laneOn   = cfgWrEn && cfgByteEn[l];
    assign hit0[l]  = laneOn &&
      ((byteAddr == BA_W'(LEG0_OFS) && laneByte[LEG0_BIT]) ||
       (byteAddr == BA_W'(UDMA_OFS) && laneByte[UINT_BIT]));
    assign hit1[l]  = laneOn &&
      ((byteAddr == BA_W'(LEG1_OFS) && laneByte[LEG1_BIT]) ||
       (byteAddr == BA_W'(UDMA_OFS) && laneByte[UINT_BIT+1]));
  end

  always_comb begin
    strb        = '0;
    strb.lvlChg = chanIrq ^ prevIrq;
    strb.lvlVal = chanIrq;
    strb.w1c    = {|hit1, |hit0};
    strb.blkWr  = blkWrEn;
    strb.blkVal = blkWrData;
  end

  // a write with no enabled lane must not raise any clear strobe
  assert_no_lane_no_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByteEn == '0 || !cfgWrEn) |-> (strb.w1c == '0));
endmodule

// File: rtl/ide_irq_dp.sv
module ide_irq_dp
  import ide_irq_pkg::*;
#(
  parameter bit SECONDARY_EN = 1'b0,
  parameter int DW_W         = 6,
  parameter int DATA_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DW_W-1:0]   rdDw,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [7:0]        ctrlByte,
  output logic [7:0]        progIfByte,
  output logic [7:0]        intPinByte
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES);
  localparam int BA_W  = DW_W + LW;
  localparam logic [7:0] CTRL_RST = SECONDARY_EN ? 8'h0C : 8'h04;

  logic [NUM_CH-1:0] intUdma;
  logic              intLeg0, intLeg1;
  logic [NUM_CH-1:0] blk;
  logic [7:0]        ctrlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intUdma <= '0;
      intLeg0 <= 1'b0;
      intLeg1 <= 1'b0;
      blk     <= '0;
      ctrlReg <= CTRL_RST;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        intUdma[c] <= strb.lvlChg[c] ? strb.lvlVal[c] : (intUdma[c] & ~strb.w1c[c]);
      intLeg0 <= strb.lvlChg[0] ? strb.lvlVal[0] : (intLeg0 & ~strb.w1c[0]);
      intLeg1 <= strb.lvlChg[1] ? strb.lvlVal[1] : (intLeg1 & ~strb.w1c[1]);
      if (strb.blkWr) blk <= strb.blkVal;
    end
  end

  assign irqOut     = |(intUdma & ~blk);
  assign ctrlByte   = ctrlReg;
  assign progIfByte = PROGIF_VAL;
  assign intPinByte = PIN_VAL;

  always_comb begin
    rdData = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [BA_W-1:0] ba;
      logic [7:0]      b;
      ba = {rdDw, LW'(l)};
      b  = 8'h00;
      if (ba == BA_W'(LEG0_OFS))        b[LEG0_BIT] = intLeg0;
      else if (ba == BA_W'(CTRL_OFS))   b = ctrlReg;
      else if (ba == BA_W'(LEG1_OFS))   b[LEG1_BIT] = intLeg1;
      else if (ba == BA_W'(UDMA_OFS)) begin
        b[UINT_BIT +: NUM_CH] = intUdma;
        b[UBLK_BIT +: NUM_CH] = blk;
      end
      else if (ba == BA_W'(PROGIF_OFS)) b = PROGIF_VAL;
      else if (ba == BA_W'(PIN_OFS))    b = PIN_VAL;
      rdData[8*l +: 8] = b;
    end
  end

  assert_mirror_agree_R3: assert property (@(posedge clk) disable iff (!rstN)
    (intLeg0 == intUdma[0]) && (intLeg1 == intUdma[1]));
  assert_follow_ch0_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.lvlChg[0] |=> (intUdma[0] == $past(strb.lvlVal[0])));
  assert_follow_ch1_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.lvlChg[1] |=> (intUdma[1] == $past(strb.lvlVal[1])));
  assert_w1c_ch0_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.w1c[0] && !strb.lvlChg[0]) |=> (!intUdma[0] && !intLeg0));
  assert_w1c_ch1_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.w1c[1] && !strb.lvlChg[1]) |=> (!intUdma[1] && !intLeg1));
  assert_blk_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.blkWr |=> $stable(blk));
  assert_all_blocked_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (&blk) |-> !irqOut);
  assert_ctrl_const_R6: assert property (@(posedge clk) disable iff (!rstN)
    $stable(ctrlReg));
endmodule

// File: rtl/ide_irq_mirror.sv
module ide_irq_mirror
  import ide_irq_pkg::*;
#(
  parameter bit SECONDARY_EN = 1'b0,
  parameter int DW_W         = 6,
  parameter int DATA_W       = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          chanIrq,
  input  logic                cfgWrEn,
  input  logic [DW_W-1:0]     cfgWrDw,
  input  logic [DATA_W/8-1:0] cfgByteEn,
  input  logic [DATA_W-1:0]   cfgWrData,
  input  logic                blkWrEn,
  input  logic [1:0]          blkWrData,
  input  logic [DW_W-1:0]     cfgRdDw,
  output logic [DATA_W-1:0]   cfgRdData,
  output logic                irqOut,
  output logic [7:0]          ctrlByte,
  output logic [7:0]          progIfByte,
  output logic [7:0]          intPinByte
);
  strobe_t strb;

  ide_irq_ctrl #(.DW_W(DW_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanIrq(chanIrq),
    .cfgWrEn(cfgWrEn), .cfgWrDw(cfgWrDw), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .blkWrEn(blkWrEn), .blkWrData(blkWrData),
    .strb(strb)
  );

  ide_irq_dp #(.SECONDARY_EN(SECONDARY_EN), .DW_W(DW_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdDw(cfgRdDw), .rdData(cfgRdData),
    .irqOut(irqOut), .ctrlByte(ctrlByte), .progIfByte(progIfByte),
    .intPinByte(intPinByte)
  );
endmodule

// File: tb/ide_irq_mirror_tb.sv
module ide_irq_mirror_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  chanIrq = '0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgWrDw = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic        blkWrEn = 1'b0;
  logic [1:0]  blkWrData = '0;
  logic [5:0]  cfgRdDw = 6'h1C;
  logic [31:0] cfgRdData;
  logic        irqOut;
  logic [7:0]  ctrlByte, progIfByte, intPinByte;
  int nRun = 0, nFail = 0;

  ide_irq_mirror u_dut (
    .clk(clk), .rstN(rstN), .chanIrq(chanIrq), .cfgWrEn(cfgWrEn),
    .cfgWrDw(cfgWrDw), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .blkWrEn(blkWrEn), .blkWrData(blkWrData), .cfgRdDw(cfgRdDw),
    .cfgRdData(cfgRdData), .irqOut(irqOut), .ctrlByte(ctrlByte),
    .progIfByte(progIfByte), .intPinByte(intPinByte)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  ch;
    logic        wr;
    logic [5:0]  dw;
    logic [3:0]  be;
    logic [31:0] data;
    logic        bEn;
    logic [1:0]  bVal;
    logic        eIrq;
    logic [7:0]  e71;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b0, 2'b00, 1'b1, 8'h04},
    '{2'b11, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b0, 2'b00, 1'b1, 8'h0C},
    '{2'b11, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b1, 2'b01, 1'b1, 8'h1C},
    '{2'b11, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b1, 2'b11, 1'b0, 8'h3C},
    '{2'b11, 1'b1, 6'h1C, 4'b0010, 32'h0000_0400, 1'b0, 2'b00, 1'b0, 8'h38},
    '{2'b11, 1'b1, 6'h15, 4'b1000, 32'h1000_0000, 1'b0, 2'b00, 1'b0, 8'h30},
    '{2'b10, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b0, 2'b00, 1'b0, 8'h30},
    '{2'b10, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b1, 2'b00, 1'b0, 8'h00},
    '{2'b11, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b0, 2'b00, 1'b1, 8'h04},
    '{2'b11, 1'b1, 6'h1C, 4'b0010, 32'h0000_3C00, 1'b0, 2'b00, 1'b0, 8'h00},
    '{2'b01, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b0, 2'b00, 1'b0, 8'h00},
    '{2'b11, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b0, 2'b00, 1'b1, 8'h08},
    '{2'b11, 1'b1, 6'h1C, 4'b0000, 32'h0000_0800, 1'b0, 2'b00, 1'b1, 8'h08},
    '{2'b11, 1'b1, 6'h15, 4'b1000, 32'h0,         1'b0, 2'b00, 1'b1, 8'h08},
    '{2'b11, 1'b1, 6'h14, 4'b1111, 32'hFFFF_FFFF, 1'b0, 2'b00, 1'b1, 8'h08},
    '{2'b10, 1'b0, 6'h00, 4'b0000, 32'h0,         1'b0, 2'b00, 1'b1, 8'h08}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [5:0] dw);
    cfgRdDw = dw;
    #1;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held
    check("R1 irq in reset", 32'(irqOut), 32'h0);
    check("R1 ctrlByte", 32'(ctrlByte), 32'h04);
    rstN = 1'b1;
    @(negedge clk);
    readAt(6'h1C);
    check("R1 byte71 after reset", 32'(cfgRdData[15:8]), 32'h00);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      chanIrq   = VEC[i].ch;
      cfgWrEn   = VEC[i].wr;
      cfgWrDw   = VEC[i].dw;
      cfgByteEn = VEC[i].be;
      cfgWrData = VEC[i].data;
      blkWrEn   = VEC[i].bEn;
      blkWrData = VEC[i].bVal;
      @(negedge clk);
      cfgWrEn = 1'b0; blkWrEn = 1'b0;
      readAt(6'h1C);
      check($sformatf("R8 irq vec%0d", i), 32'(irqOut), 32'(VEC[i].eIrq));
      check($sformatf("R4 R5 R7 R9 R10 byte71 vec%0d", i), 32'(cfgRdData[15:8]), 32'(VEC[i].e71));
    end

    // R5: level change wins over a simultaneous clear
    chanIrq = 2'b11; cfgWrEn = 1'b1; cfgWrDw = 6'h14; cfgByteEn = 4'b0001; cfgWrData = 32'h04;
    @(negedge clk);
    cfgWrEn = 1'b0;
    readAt(6'h1C);
    check("R5 level beats clear", 32'(cfgRdData[15:8]), 32'h0C);
    // R2 R3: legacy copies
    readAt(6'h14);
    check("R3 legacy ch0 bit", 32'(cfgRdData[2]), 32'h1);
    check("R6 ctrl byte 0x51 unchanged", 32'(cfgRdData[15:8]), 32'h04);
    readAt(6'h15);
    check("R2 legacy ch1 bit", 32'(cfgRdData[28]), 32'h1);

    // R5 R6: clear ch1 via byte 0x57 with all ones
    cfgWrEn = 1'b1; cfgWrDw = 6'h15; cfgByteEn = 4'b1000; cfgWrData = 32'hFFFF_FFFF;
    @(negedge clk);
    cfgWrEn = 1'b0;
    readAt(6'h15);
    check("R5 R6 legacy 0x57 after clear", cfgRdData, 32'h0);
    readAt(6'h1C);
    check("R3 byte71 mirror of clear", 32'(cfgRdData[15:8]), 32'h04);
    check("R8 ch0 still drives irq", 32'(irqOut), 32'h1);

    // R1: identification bytes
    readAt(6'h02);
    check("R1 progIf read", 32'(cfgRdData[15:8]), 32'h8F);
    readAt(6'h0F);
    check("R1 intPin read", 32'(cfgRdData[15:8]), 32'h01);
    check("R1 progIf port", 32'(progIfByte), 32'h8F);
    check("R1 intPin port", 32'(intPinByte), 32'h01);

    // R1: reset from an active state
    blkWrEn = 1'b1; blkWrData = 2'b10;
    @(negedge clk);
    blkWrEn = 1'b0;
    chanIrq = 2'b00; rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    readAt(6'h1C);
    check("R1 irq after reset", 32'(irqOut), 32'h0);
    check("R1 byte71 after reset", 32'(cfgRdData[15:8]), 32'h00);
    check("R1 ctrlByte after reset", 32'(ctrlByte), 32'h04);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end
endmodule